// File: doc/BRIEF.md
# Parity Bus Transceiver with Latched Error Flag

The block joins an eight-bit A port to a nine-bit B port, where the ninth B bit carries odd parity. Direction is chosen by two active-low enables. When A drives B, the block passes the A byte through unchanged and adds a parity bit. The bit is chosen so that the nine B bits hold an odd number of ones. When B drives A, the byte passes through unchanged and the nine received bits are checked for odd parity. Each port has its own drive-enable output in place of a tristate wire. A port that is not driven reads as zero on its output vector.

The check result feeds an error flag that is updated on each clock edge. While the flag enable is high, the flag follows the live check one cycle later. While the enable is low, the flag holds its value. An active-low clear empties the flag and overrides the enable. The error output is modelled as open drain: an active-low level plus a pull-down enable that is asserted only while an error is flagged.

Pulling both enables low selects a diagnostic mode. In this mode A still drives B, but the parity bit is inverted on purpose. Feeding that B word back into another checker therefore raises an error, which tests the error path.

Top module: `par_xcvr`

## Requirements
- R1: With oe_b_n low and oe_a_n high (A to B), b_out equals a_in, b_drive is 1 and a_drive is 0.
- R2: In A-to-B mode, b_par_out makes the nine bits {b_out, b_par_out} hold an odd number of ones.
- R3: With oe_a_n low and oe_b_n high (B to A), a_out equals b_in, a_drive is 1 and b_drive is 0.
- R4: In B-to-A mode, with flag_le high and flag_clr_n high, the flag one clock later is set exactly when {b_in, b_par_in} holds an even number of ones. This covers a flipped parity bit and any single flipped data bit.
- R5: With both enables low (diagnostic), b_out equals a_in, b_drive is 1, a_drive is 0, and {b_out, b_par_out} holds an even number of ones.
- R6: With both enables high, a_drive and b_drive are 0, and a_out, b_out and b_par_out read 0.
- R7: While flag_le is low and flag_clr_n is high, the flag keeps its value whatever the mode and data.
- R8: flag_clr_n low empties the flag at the next clock edge, even when flag_le is high and the live check reports an error.
- R9: Outside B-to-A mode the live check reports no error, so with flag_le high the flag empties one clock later.
- R10: While the flag is set, err_n is 0 and err_drive is 1. While it is empty, err_n is 1 and err_drive is 0.
- R11: rst high at a clock edge empties the flag, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| rst | input | 1 | Synchronous active-high reset of the flag |
| oe_a_n | input | 1 | Active-low enable, drives the A port |
| oe_b_n | input | 1 | Active-low enable, drives the B port |
| a_in | input | DATA_W | Data received on the A port |
| a_out | output | DATA_W | Data driven onto the A port |
| a_drive | output | 1 | A port drive enable |
| b_in | input | DATA_W | Data received on the B port |
| b_par_in | input | 1 | Parity bit received on the B port |
| b_out | output | DATA_W | Data driven onto the B port |
| b_par_out | output | 1 | Parity bit driven onto the B port |
| b_drive | output | 1 | B port drive enable |
| flag_le | input | 1 | Flag update enable (high follows, low holds) |
| flag_clr_n | input | 1 | Active-low flag clear, overrides flag_le |
| err_n | output | 1 | Active-low error level |
| err_drive | output | 1 | Pull-down enable for the error line |

## Verification
All 256 byte values are applied in the isolate, A-to-B, diagnostic and B-to-A modes. The same byte therefore shows whether direction, pass-through and parity polarity depend on the mode alone and not on the data. In B-to-A mode each byte is sent with its correct parity, with the parity bit flipped, and with one data bit flipped. This separates a true odd-parity check from a check that looks only at the data or only at the parity bit. Short hand-built sequences toggle flag_le, flag_clr_n and rst around a latched error. They separate holding from following, and show that clear and reset override the enable.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'd0,
    MODE_A2B     = 2'd1,
    MODE_B2A     = 2'd2,
    MODE_DIAG    = 2'd3
  } xfer_mode_e;

endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
  import xcvr_pkg::*;
(
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output xfer_mode_e mode
);

  always_comb begin
    unique case ({oe_a_n, oe_b_n})
      2'b11:   mode = MODE_ISOLATE;
      2'b10:   mode = MODE_A2B;
      2'b01:   mode = MODE_B2A;
      default: mode = MODE_DIAG;
    endcase
  end

endmodule

// File: rtl/xcvr_parity_path.sv
module xcvr_parity_path
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  xfer_mode_e        mode,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_drive,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_drive,
  output logic              chk_err
);

  localparam int CHAIN_W = DATA_W + 1;

  logic [CHAIN_W-1:0] a_chain;
  logic [CHAIN_W-1:0] b_chain;
  logic               a_ones_odd;
  logic               b_word_odd;

  assign a_chain[0] = 1'b0;
  assign b_chain[0] = b_par_in;

  // Ripple XOR over each data bit; the B chain starts from the received parity.
  for (genvar g = 0; g < DATA_W; g++) begin : g_xor
    assign a_chain[g+1] = a_chain[g] ^ a_in[g];
    assign b_chain[g+1] = b_chain[g] ^ b_in[g];
  end

  assign a_ones_odd = a_chain[CHAIN_W-1];
  assign b_word_odd = b_chain[CHAIN_W-1];

  always_comb begin
    a_out     = '0;
    a_drive   = 1'b0;
    b_out     = '0;
    b_par_out = 1'b0;
    b_drive   = 1'b0;
    chk_err   = 1'b0;
    unique case (mode)
      MODE_A2B: begin
        b_out     = a_in;
        b_par_out = ~a_ones_odd;
        b_drive   = 1'b1;
      end
      MODE_DIAG: begin
        b_out     = a_in;
        b_par_out = a_ones_odd;
        b_drive   = 1'b1;
      end
      MODE_B2A: begin
        a_out   = b_in;
        a_drive = 1'b1;
        chk_err = ~b_word_odd;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/xcvr_err_latch.sv
module xcvr_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic le,
  input  logic clr_n,
  input  logic live_err,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (!clr_n) begin
      flag <= 1'b0;
    end else if (le) begin
      flag <= live_err;
    end
  end

  AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (!le && clr_n) |=> $stable(flag)); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |=> !flag); // R8
  AST_FOLLOW_LIVE: assert property (@(posedge clk) disable iff (rst)
    (le && clr_n) |=> (flag == $past(live_err))); // R4
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> !flag); // R11

endmodule

// File: rtl/par_xcvr.sv
module par_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_drive,
  input  logic [DATA_W-1:0] b_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_par_out,
  output logic              b_drive,
  input  logic              flag_le,
  input  logic              flag_clr_n,
  output logic              err_n,
  output logic              err_drive
);

  xfer_mode_e mode;
  logic       chk_err;
  logic       flag;

  xcvr_mode_dec u_mode_dec (
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .mode   (mode)
  );

  xcvr_parity_path #(.DATA_W(DATA_W)) u_path (
    .mode      (mode),
    .a_in      (a_in),
    .b_in      (b_in),
    .b_par_in  (b_par_in),
    .a_out     (a_out),
    .a_drive   (a_drive),
    .b_out     (b_out),
    .b_par_out (b_par_out),
    .b_drive   (b_drive),
    .chk_err   (chk_err)
  );

  xcvr_err_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .le       (flag_le),
    .clr_n    (flag_clr_n),
    .live_err (chk_err),
    .flag     (flag)
  );

  assign err_n     = ~flag;
  assign err_drive = flag;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(a_drive && b_drive)); // R6
  AST_A2B_ODD: assert property (@(posedge clk) disable iff (rst)
    (oe_a_n && !oe_b_n) |-> (^{b_out, b_par_out})); // R2
  AST_DIAG_EVEN: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && !oe_b_n) |-> !(^{b_out, b_par_out})); // R5
  AST_NO_ERR_OFF_B2A: assert property (@(posedge clk) disable iff (rst)
    (!(oe_b_n && !oe_a_n) && flag_le) |=> !flag); // R9

endmodule

// File: tb/par_xcvr_bench.sv
module par_xcvr_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] a_out;
  logic         a_drive;
  logic [W-1:0] b_in = '0;
  logic         b_par_in = 1'b0;
  logic [W-1:0] b_out;
  logic         b_par_out;
  logic         b_drive;
  logic         flag_le = 1'b1;
  logic         flag_clr_n = 1'b1;
  logic         err_n;
  logic         err_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  par_xcvr #(.DATA_W(W)) u_par_xcvr (
    .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out),
    .b_par_out(b_par_out), .b_drive(b_drive),
    .flag_le(flag_le), .flag_clr_n(flag_clr_n),
    .err_n(err_n), .err_drive(err_drive)
  );

  function automatic int ones(input logic [W:0] v);
    int n = 0;
    for (int i = 0; i <= W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Flag check at the port: err_n and err_drive together (R10).
  task automatic chk_flag(input string req, input bit exp_set);
    chk({req, " err_n"}, int'(err_n), int'(!exp_set));
    chk({req, " R10 err_drive"}, int'(err_drive), int'(exp_set));
  endtask

  task automatic set_mode(input bit a_n, input bit b_n);
    oe_a_n = a_n;
    oe_b_n = b_n;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    @(negedge clk);
    // R11: reset holds flag empty even with a live error present.
    set_mode(1'b0, 1'b1);
    b_in = 8'h00; b_par_in = 1'b0;
    tick(); tick();
    chk_flag("R11 reset", 1'b0);
    rst = 1'b0;

    // R6: isolation sweep
    set_mode(1'b1, 1'b1);
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v); b_in = ~W'(v); b_par_in = v[0];
      #1;
      chk("R6 a_drive", int'(a_drive), 0);
      chk("R6 b_drive", int'(b_drive), 0);
      chk("R6 a_out", int'(a_out), 0);
      chk("R6 b_out", int'(b_out), 0);
      chk("R6 b_par_out", int'(b_par_out), 0);
    end
    tick();
    chk_flag("R9 isolate", 1'b0);

    // R1/R2: A to B sweep
    set_mode(1'b1, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v); b_in = W'(v + 1); b_par_in = 1'b0;
      #1;
      chk("R1 b_out", int'(b_out), v);
      chk("R1 b_drive", int'(b_drive), 1);
      chk("R1 a_drive", int'(a_drive), 0);
      chk("R2 parity", int'(b_par_out), (ones({1'b0, W'(v)}) % 2 == 0) ? 1 : 0);
    end
    tick();
    chk_flag("R9 a2b", 1'b0);

    // R5: diagnostic sweep with inverted parity
    set_mode(1'b0, 1'b0);
    for (int v = 0; v < 256; v++) begin
      a_in = W'(v);
      #1;
      chk("R5 b_out", int'(b_out), v);
      chk("R5 b_drive", int'(b_drive), 1);
      chk("R5 a_drive", int'(a_drive), 0);
      chk("R5 parity", int'(b_par_out), ones({1'b0, W'(v)}) % 2);
    end
    tick();
    chk_flag("R9 diag", 1'b0);

    // R3/R4: B to A sweep with good parity, flipped parity, flipped data bit
    set_mode(1'b0, 1'b1);
    for (int v = 0; v < 256; v++) begin
      p = (ones({1'b0, W'(v)}) % 2 == 0) ? 1 : 0;
      a_in = ~W'(v);
      b_in = W'(v); b_par_in = p[0];
      #1;
      chk("R3 a_out", int'(a_out), v);
      chk("R3 a_drive", int'(a_drive), 1);
      chk("R3 b_drive", int'(b_drive), 0);
      tick();
      chk_flag("R4 good parity", 1'b0);
      b_par_in = ~p[0];
      tick();
      chk_flag("R4 bad parity bit", 1'b1);
      b_par_in = p[0];
      b_in = W'(v) ^ (W'(1) << (v % W));
      tick();
      chk_flag("R4 bad data bit", 1'b1);
    end

    // R7: hold an error while closed
    b_in = 8'h3C; b_par_in = 1'b0;   // four ones + 0 -> even -> error
    tick();
    chk_flag("R4 latch error", 1'b1);
    flag_le = 1'b0;
    b_par_in = 1'b1;
    tick(); tick(); tick();
    chk_flag("R7 hold error", 1'b1);
    set_mode(1'b1, 1'b0);
    tick();
    chk_flag("R7 hold across mode", 1'b1);
    // R9: reopen outside B-to-A empties the flag
    flag_le = 1'b1;
    tick();
    chk_flag("R9 reopen a2b", 1'b0);

    // R7: hold empty while bad parity arrives
    set_mode(1'b0, 1'b1);
    b_in = 8'h3C; b_par_in = 1'b1;
    tick();
    flag_le = 1'b0;
    b_par_in = 1'b0;
    tick(); tick();
    chk_flag("R7 hold empty", 1'b0);

    // R8: clear overrides enable
    flag_le = 1'b1;
    tick();
    chk_flag("R4 relatch", 1'b1);
    flag_clr_n = 1'b0;
    tick();
    chk_flag("R8 clear over le", 1'b0);
    flag_clr_n = 1'b1;
    tick();
    chk_flag("R4 follow after clear", 1'b1);
    flag_le = 1'b0;
    flag_clr_n = 1'b0;
    tick();
    chk_flag("R8 clear while closed", 1'b0);
    flag_clr_n = 1'b1;
    tick();
    chk_flag("R7 stays empty", 1'b0);

    // R11: synchronous reset empties a latched error
    flag_le = 1'b1;
    tick();
    chk_flag("R4 relatch2", 1'b1);
    rst = 1'b1;
    tick();
    chk_flag("R11 reset clears", 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule